// File: doc/BRIEF.md
# E3 Loss-of-Signal Detector

This block watches the serial receive bit stream of an E3 line, one bit per clock on which a valid strobe is high. It keeps a loss-of-signal flag. The flag sets after a long unbroken run of zero bits. It drops only after a whole observation window of bits contains no short burst of zeros. Because the rule that sets the flag differs from the rule that clears it, the flag has hysteresis and does not chatter on a marginal line.

Two outputs go to the rest of the receiver. The first is the current flag level. The second is a single-cycle change pulse that fires on every transition of that level, in either direction. Upstream logic supplies the recovered bits with a qualifying strobe. Line decoding, frame alignment and register access belong to other blocks.

Top module: `e3los_detector`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `losActive` and `losToggle` are 0. All run and window counts restart from zero, so a fresh run of 32 zero bits is needed to declare.
- R2: With `losActive` low, the 32nd consecutive valid zero bit sets `losActive` to 1 at the clock edge that samples that bit. After 31 such zeros it is still 0.
- R3: With `losActive` low, a valid one bit restarts the zero run. Thirty-one zeros, a one and then 31 zeros leave `losActive` at 0.
- R4: On cycles with `bitValid` low, `rxBit` is ignored and no state changes. Zeros separated by invalid cycles still count as one consecutive run.
- R5: With `losActive` high, a single valid one bit does not clear it.
- R6: With `losActive` high, the flag clears at the edge that samples the 32nd valid bit of a clearing window that holds no run of four zeros. Runs of one to three zeros are allowed inside the window. The window opens with the first valid bit after declaration.
- R7: While clearing, a fourth consecutive valid zero restarts the window, and so does every further zero of that run. The next window begins with the following valid bit.
- R8: If the 32nd bit of a window is also the fourth zero of a run, the window restarts and `losActive` stays 1.
- R9: `losToggle` is 1 for exactly one clock cycle, in the same cycle in which `losActive` takes its new value. This holds for both the set and the clear transitions, and `losToggle` is 0 in all other cycles.
- R10: When the flag clears, the zero-run count restarts from zero. Zeros received before the clearing edge do not count toward the next declaration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bitValid | input | 1 | High on cycles that carry a received bit |
| rxBit | input | 1 | Received data bit, sampled when `bitValid` is high |
| losActive | output | 1 | Current loss-of-signal level |
| losToggle | output | 1 | One-cycle pulse on every change of `losActive` |

## Verification
Two rules can fall on the same bit while the flag is clearing: completion of the 32-bit window and detection of a fourth consecutive zero. The bench provokes this by sending 28 ones and then four zeros right after a declaration, so the last bit of the window is also the fourth zero. It judges the result at the ports. `losActive` must stay high with no `losToggle` pulse, and a full 32 further clean bits must then be needed before the clear happens.

// File: rtl/e3los_pkg.sv
package e3los_pkg;

  // Strobes issued by the control to the counter datapath.
  typedef struct packed {
    logic incZero;
    logic clrZero;
    logic incShort;
    logic clrShort;
    logic incWin;
    logic clrWin;
  } ctrlStrobes_t;

  // Terminal-count flags returned by the datapath.
  typedef struct packed {
    logic zeroLast;
    logic shortLast;
    logic winLast;
  } dpFlags_t;

  typedef enum logic [0:0] {
    ST_SIGNAL = 1'b0,
    ST_LOST   = 1'b1
  } losState_t;

  localparam int NUM_COUNTERS = 3;
  localparam int IDX_ZERO  = 0;
  localparam int IDX_SHORT = 1;
  localparam int IDX_WIN   = 2;

endpackage

// File: rtl/e3los_counter.sv
module e3los_counter #(
  parameter int LIMIT = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic clr,
  output logic lastStep
);
  localparam int W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] TOP = W'(LIMIT - 1);

  logic [W-1:0] count;

  // Saturating up-counter; clear has priority over increment.
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (inc && (count != TOP)) begin
      count <= count + 1'b1;
    end
  end

  // High when the next increment would complete the count.
  assign lastStep = (count == TOP);

endmodule

// File: rtl/e3los_datapath.sv
module e3los_datapath
  import e3los_pkg::*;
#(
  parameter int DECLARE_ZEROS = 32,
  parameter int CLEAR_RUN     = 4,
  parameter int CLEAR_WINDOW  = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  ctrlStrobes_t strobes,
  output dpFlags_t     flags
);
  logic [NUM_COUNTERS-1:0] incVec;
  logic [NUM_COUNTERS-1:0] clrVec;
  logic [NUM_COUNTERS-1:0] lastVec;

  assign incVec[IDX_ZERO]  = strobes.incZero;
  assign incVec[IDX_SHORT] = strobes.incShort;
  assign incVec[IDX_WIN]   = strobes.incWin;
  assign clrVec[IDX_ZERO]  = strobes.clrZero;
  assign clrVec[IDX_SHORT] = strobes.clrShort;
  assign clrVec[IDX_WIN]   = strobes.clrWin;

  for (genvar i = 0; i < NUM_COUNTERS; i++) begin : g_cnt
    localparam int LIM = (i == IDX_ZERO)  ? DECLARE_ZEROS :
                         (i == IDX_SHORT) ? CLEAR_RUN     : CLEAR_WINDOW;
    e3los_counter #(.LIMIT(LIM)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .inc      (incVec[i]),
      .clr      (clrVec[i]),
      .lastStep (lastVec[i])
    );
  end

  assign flags.zeroLast  = lastVec[IDX_ZERO];
  assign flags.shortLast = lastVec[IDX_SHORT];
  assign flags.winLast   = lastVec[IDX_WIN];

endmodule

// File: rtl/e3los_control.sv
module e3los_control
  import e3los_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         bitValid,
  input  logic         rxBit,
  input  dpFlags_t     flags,
  output ctrlStrobes_t strobes,
  output logic         losActive,
  output logic         losToggle
);
  losState_t state, stateNext;
  logic      toggleNext;

  always_comb begin
    strobes    = '0;
    stateNext  = state;
    toggleNext = 1'b0;
    if (bitValid) begin
      unique case (state)
        ST_SIGNAL: begin
          if (rxBit) begin
            strobes.clrZero = 1'b1;
          end else if (flags.zeroLast) begin
            // Declaration: open a fresh clearing window.
            stateNext        = ST_LOST;
            toggleNext       = 1'b1;
            strobes.clrZero  = 1'b1;
            strobes.clrShort = 1'b1;
            strobes.clrWin   = 1'b1;
          end else begin
            strobes.incZero = 1'b1;
          end
        end
        ST_LOST: begin
          if (rxBit) begin
            strobes.clrZero  = 1'b1;
            strobes.clrShort = 1'b1;
          end else begin
            strobes.incZero  = 1'b1;
            strobes.incShort = 1'b1;
          end
          if (!rxBit && flags.shortLast) begin
            // Fourth (or later) zero of a run: window restarts; wins over completion.
            strobes.clrWin = 1'b1;
          end else if (flags.winLast) begin
            stateNext        = ST_SIGNAL;
            toggleNext       = 1'b1;
            strobes.incZero  = 1'b0;
            strobes.clrZero  = 1'b1;
            strobes.clrShort = 1'b1;
            strobes.clrWin   = 1'b1;
          end else begin
            strobes.incWin = 1'b1;
          end
        end
        default: stateNext = ST_SIGNAL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_SIGNAL;
      losToggle <= 1'b0;
    end else begin
      state     <= stateNext;
      losToggle <= toggleNext;
    end
  end

  assign losActive = (state == ST_LOST);

endmodule

// File: rtl/e3los_detector.sv
module e3los_detector
  import e3los_pkg::*;
#(
  parameter int DECLARE_ZEROS = 32,
  parameter int CLEAR_RUN     = 4,
  parameter int CLEAR_WINDOW  = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic bitValid,
  input  logic rxBit,
  output logic losActive,
  output logic losToggle
);
  ctrlStrobes_t strobes;
  dpFlags_t     flags;

  e3los_control u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .bitValid  (bitValid),
    .rxBit     (rxBit),
    .flags     (flags),
    .strobes   (strobes),
    .losActive (losActive),
    .losToggle (losToggle)
  );

  e3los_datapath #(
    .DECLARE_ZEROS (DECLARE_ZEROS),
    .CLEAR_RUN     (CLEAR_RUN),
    .CLEAR_WINDOW  (CLEAR_WINDOW)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .flags   (flags)
  );

endmodule

// File: rtl/e3los_checker.sv
module e3los_checker #(
  parameter int DECLARE_ZEROS = 32,
  parameter int CLEAR_RUN     = 4,
  parameter int CLEAR_WINDOW  = 32
) (
  input logic clk,
  input logic rst,
  input logic bitValid,
  input logic rxBit,
  input logic losActive,
  input logic losToggle
);
  logic [15:0] zeroSeen;
  logic [15:0] cleanSeen;
  logic [15:0] shortSeen;

  // Observed stream history, rebuilt from the ports.
  always_ff @(posedge clk) begin
    if (rst) begin
      zeroSeen  <= '0;
      shortSeen <= '0;
      cleanSeen <= '0;
    end else if (bitValid) begin
      if (rxBit) begin
        zeroSeen  <= '0;
        shortSeen <= '0;
        if (cleanSeen != 16'hFFFF) cleanSeen <= cleanSeen + 1'b1;
      end else begin
        if (zeroSeen != 16'hFFFF) zeroSeen <= zeroSeen + 1'b1;
        if (shortSeen != 16'hFFFF) shortSeen <= shortSeen + 1'b1;
        if (32'(shortSeen) + 1 >= CLEAR_RUN) cleanSeen <= '0;
        else if (cleanSeen != 16'hFFFF) cleanSeen <= cleanSeen + 1'b1;
      end
    end
  end

  assert_declare_run_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(losActive) |-> (32'(zeroSeen) >= DECLARE_ZEROS));

  assert_clear_window_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(losActive) |-> (32'(cleanSeen) >= CLEAR_WINDOW));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !bitValid |=> ($stable(losActive) && !losToggle));

  assert_one_keeps_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (bitValid && rxBit && !losActive) |=> !losActive);

  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (rst)
    losToggle |=> !losToggle);

  assert_pulse_aligned_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(losActive) != losActive) == losToggle);

endmodule

bind e3los_detector e3los_checker #(
  .DECLARE_ZEROS (DECLARE_ZEROS),
  .CLEAR_RUN     (CLEAR_RUN),
  .CLEAR_WINDOW  (CLEAR_WINDOW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bitValid  (bitValid),
  .rxBit     (rxBit),
  .losActive (losActive),
  .losToggle (losToggle)
);

// File: tb/e3los_detector_test.sv
module e3los_detector_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bitValid = 1'b0;
  logic rxBit = 1'b0;
  logic losActive;
  logic losToggle;
  int   nChecks = 0;
  int   nFails  = 0;

  always #10 clk = ~clk;

  e3los_detector uut (
    .clk       (clk),
    .rst       (rst),
    .bitValid  (bitValid),
    .rxBit     (rxBit),
    .losActive (losActive),
    .losToggle (losToggle)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive at negedge; on return the outputs reflect the edge in between.
  task automatic sendBit(input logic b);
    bitValid = 1'b1;
    rxBit    = b;
    @(negedge clk);
  endtask

  task automatic sendRun(input int n, input logic b);
    for (int i = 0; i < n; i++) sendBit(b);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      bitValid = 1'b0;
      rxBit    = i[0];
      @(negedge clk);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    bitValid = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 level in reset", losActive, 1'b0);
    check("R1 pulse in reset", losToggle, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 level after reset", losActive, 1'b0);
    check("R1 pulse after reset", losToggle, 1'b0);
  endtask

  task automatic declareLos();
    sendRun(32, 1'b0);
    check("R2 declared", losActive, 1'b1);
  endtask

  task automatic testDeclare();
    doReset();
    sendRun(31, 1'b0);
    check("R2 31 zeros", losActive, 1'b0);
    sendBit(1'b0);
    check("R2 32nd zero", losActive, 1'b1);
    check("R9 set pulse", losToggle, 1'b1);
    sendBit(1'b0);
    check("R9 pulse one cycle", losToggle, 1'b0);
    check("R2 stays", losActive, 1'b1);
  endtask

  task automatic testRunBreak();
    doReset();
    sendRun(31, 1'b0);
    sendBit(1'b1);
    sendRun(31, 1'b0);
    check("R3 one restarts run", losActive, 1'b0);
    sendBit(1'b0);
    check("R3 fresh 32 declares", losActive, 1'b1);
  endtask

  task automatic testIdle();
    doReset();
    sendRun(16, 1'b0);
    idle(5);
    check("R4 idle no change", losActive, 1'b0);
    sendRun(15, 1'b0);
    check("R4 run spans gap 31", losActive, 1'b0);
    sendBit(1'b0);
    check("R4 run spans gap 32", losActive, 1'b1);
    idle(40);
    check("R4 idle while lost", losActive, 1'b1);
    check("R4 no pulse in idle", losToggle, 1'b0);
  endtask

  task automatic testSingleOne();
    doReset();
    declareLos();
    sendBit(1'b1);
    check("R5 single one keeps", losActive, 1'b1);
    sendBit(1'b0);
    check("R5 still lost", losActive, 1'b1);
  endtask

  task automatic testClearAndRecount();
    doReset();
    declareLos();
    for (int k = 0; k < 7; k++) begin
      sendBit(1'b1);
      sendRun(3, 1'b0);
    end
    sendBit(1'b1);
    sendRun(2, 1'b0);
    check("R6 31 window bits", losActive, 1'b1);
    check("R9 no early pulse", losToggle, 1'b0);
    sendBit(1'b0);
    check("R6 cleared at 32", losActive, 1'b0);
    check("R9 clear pulse", losToggle, 1'b1);
    sendRun(29, 1'b0);
    check("R9 pulse gone", losToggle, 1'b0);
    check("R10 old zeros ignored", losActive, 1'b0);
    sendRun(2, 1'b0);
    check("R10 31 after clear", losActive, 1'b0);
    sendBit(1'b0);
    check("R10 32 after clear", losActive, 1'b1);
  endtask

  task automatic testRestart();
    doReset();
    declareLos();
    sendRun(20, 1'b1);
    sendRun(6, 1'b0);
    sendRun(31, 1'b1);
    check("R7 window restarted", losActive, 1'b1);
    sendBit(1'b1);
    check("R7 clear after new window", losActive, 1'b0);
  endtask

  task automatic testCollision();
    doReset();
    declareLos();
    sendRun(28, 1'b1);
    sendRun(4, 1'b0);
    check("R8 restart wins", losActive, 1'b1);
    check("R8 no pulse", losToggle, 1'b0);
    sendRun(31, 1'b1);
    check("R8 31 after restart", losActive, 1'b1);
    sendBit(1'b1);
    check("R8 clear after restart", losActive, 1'b0);
    check("R9 pulse on clear", losToggle, 1'b1);
  endtask

  initial begin
    #(200000 * 20);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    @(negedge clk);
    testDeclare();
    testRunBreak();
    testIdle();
    testSingleOne();
    testClearAndRecount();
    testRestart();
    testCollision();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule